// File: doc/BRIEF.md
# Flash erase and byte-program unlock controller

This block is the guard that stands between an 8-bit microcontroller's register writes and the flash macro. Software cannot erase flash with a single store. A page erase first needs a write of the target page number. A whole-array erase first needs an enable bit set to 1, and the debug port must be enabled. After that, a specific command byte starts the erase. Every erase that is issued disarms both paths. Software must therefore re-arm before each new erase.

The same block steers the processor's external-data byte writes. While a program-write-enable bit is set, the next such write goes to program flash at the pointer address. The enable then clears itself. Otherwise these writes go to data RAM. The enable bit cannot be changed while global interrupts are on. While the flash macro reports busy, the block drops erase commands and flash byte writes, and the command register reads back as zero. All request and write outputs are registered, so each one appears one clock after the input that causes it.

Top module: `flash_unlock_ctrl`

## Requirements
- R1: After a synchronous reset, every request and write strobe is 0, the erase page output is 0, the program-write-enable readback is 0, and the command readback is 0x00.
- R2: Writing 0x55 to the command register (select 0) after a write to the page register (select 1, bits 6:0 = page 0..127) gives a one-cycle `erase_page_req_o` pulse on the next clock, with that page on `erase_page_o`.
- R3: Writing 0xAA to the command register gives a one-cycle `erase_mass_req_o` pulse on the next clock. This requires that the enable register (select 2, bit 0) holds 1 and that `dbg_en_i` is high.
- R4: Any command value other than 0x55 or 0xAA issues no request and leaves both arming conditions intact.
- R5: A 0x55 command with no page-register write since the last issued erase is dropped.
- R6: A 0xAA command with the enable at 0, or with `dbg_en_i` low, is dropped without clearing the enable. Writing 0 to the enable disarms the whole-array erase.
- R7: Issuing either kind of erase clears both the page-written flag and the whole-array enable.
- R8: An external-data write with program-write-enable at 1 gives a one-cycle `flash_wr_o` pulse on the next clock, carrying the address and data, and no RAM write. With the enable at 0, the write produces `ram_wr_o` instead.
- R9: The program-write-enable (select 3, bit 0, readable on `pwe_o`) clears itself after a byte is written to flash.
- R10: Writes to the program-write-enable register are ignored while `gie_i` is 1.
- R11: While `flash_busy_i` is 1, erase commands are ignored, and external-data writes with the enable set are dropped: no flash write, no RAM write, enable kept. The command readback shows 0x00. Page and enable register writes are still accepted.
- R12: When not busy, the command readback shows the last command byte written while not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 command, 1 page, 2 whole-array enable, 3 program-write-enable |
| reg_wdata_i | input | 8 | Register write data |
| gie_i | input | 1 | Global interrupt enable state |
| dbg_en_i | input | 1 | Debug port enabled |
| flash_busy_i | input | 1 | Flash macro busy |
| xwr_i | input | 1 | External-data byte write strobe |
| xwr_addr_i | input | 16 | Pointer address of the byte write |
| xwr_data_i | input | 8 | Byte to write |
| cmd_rdata_o | output | 8 | Command register readback |
| pwe_o | output | 1 | Program-write-enable state |
| erase_page_req_o | output | 1 | Page erase request pulse |
| erase_mass_req_o | output | 1 | Whole-array erase request pulse |
| erase_page_o | output | 7 | Page to erase |
| flash_wr_o | output | 1 | Flash byte write pulse |
| flash_addr_o | output | 16 | Flash byte address |
| flash_data_o | output | 8 | Flash byte data |
| ram_wr_o | output | 1 | Data RAM write pulse |
| ram_addr_o | output | 16 | Data RAM address |
| ram_data_o | output | 8 | Data RAM byte |

## Verification
The bench issues a second erase command straight after a successful one, with no re-arming. A design that failed to disarm would erase twice. It also issues a page command right after a whole-array erase, which catches a design that clears only the arming of the path that fired. Commands with the debug port off and with junk values must leave the arming intact, so a design that disarms on a dropped command fails the follow-up erase. During busy, a write with the enable set must vanish entirely: a design that falls back to RAM, or clears the enable anyway, shows the wrong strobe or readback. The page number 127 checks the full width of the page field.

// File: rtl/flash_unlock_pkg.sv
package flash_unlock_pkg;
  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_PAGE = 2'd1,
    SEL_MASS = 2'd2,
    SEL_PWE  = 2'd3
  } reg_sel_e;

  localparam logic [7:0] CMD_PAGE_ERASE = 8'h55;
  localparam logic [7:0] CMD_MASS_ERASE = 8'hAA;
endpackage

// File: rtl/fu_erase_ctrl.sv
module fu_erase_ctrl
  import flash_unlock_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 7,
  parameter logic [DATA_W-1:0] PAGE_CMD = DATA_W'(CMD_PAGE_ERASE),
  parameter logic [DATA_W-1:0] MASS_CMD = DATA_W'(CMD_MASS_ERASE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              dbg_en,
  output logic [DATA_W-1:0] cmd_rdata,
  output logic              page_req,
  output logic              mass_req,
  output logic [PAGE_W-1:0] page_out
);
  logic [DATA_W-1:0] cmd_q;
  logic [PAGE_W-1:0] page_q;
  logic              page_armed_q;
  logic              mass_en_q;
  logic              cmd_wr, page_go, mass_go;

  // The command is taken only when the macro is idle.
  assign cmd_wr  = wr_en && (sel == SEL_CMD) && !busy;
  assign page_go = cmd_wr && (wdata == PAGE_CMD) && page_armed_q;
  assign mass_go = cmd_wr && (wdata == MASS_CMD) && mass_en_q && dbg_en;

  assign cmd_rdata = busy ? '0 : cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q        <= '0;
      page_q       <= '0;
      page_armed_q <= 1'b0;
      mass_en_q    <= 1'b0;
      page_req     <= 1'b0;
      mass_req     <= 1'b0;
      page_out     <= '0;
    end else begin
      page_req <= page_go;
      mass_req <= mass_go;
      if (cmd_wr) cmd_q <= wdata;
      if (page_go) page_out <= page_q;
      if (page_go || mass_go) begin
        page_armed_q <= 1'b0;
        mass_en_q    <= 1'b0;
      end else begin
        if (wr_en && (sel == SEL_PAGE)) begin
          page_q       <= wdata[PAGE_W-1:0];
          page_armed_q <= 1'b1;
        end
        if (wr_en && (sel == SEL_MASS)) mass_en_q <= wdata[0];
      end
    end
  end
endmodule

// File: rtl/fu_write_route.sv
module fu_write_route
  import flash_unlock_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              gie,
  input  logic              busy,
  input  logic              xwr,
  input  logic [ADDR_W-1:0] xaddr,
  input  logic [DATA_W-1:0] xdata,
  output logic              pwe,
  output logic              flash_wr,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [DATA_W-1:0] flash_data,
  output logic              ram_wr,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_data
);
  logic to_flash, to_ram, pwe_load;

  assign to_flash = xwr && pwe && !busy;
  assign to_ram   = xwr && !pwe;
  assign pwe_load = wr_en && (sel == SEL_PWE) && !gie;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwe        <= 1'b0;
      flash_wr   <= 1'b0;
      flash_addr <= '0;
      flash_data <= '0;
      ram_wr     <= 1'b0;
      ram_addr   <= '0;
      ram_data   <= '0;
    end else begin
      flash_wr <= to_flash;
      ram_wr   <= to_ram;
      if (to_flash) begin
        flash_addr <= xaddr;
        flash_data <= xdata;
      end
      if (to_ram) begin
        ram_addr <= xaddr;
        ram_data <= xdata;
      end
      // A completed flash byte disarms; it wins over a same-cycle load.
      if (to_flash)      pwe <= 1'b0;
      else if (pwe_load) pwe <= wdata[0];
    end
  end
endmodule

// File: rtl/flash_unlock_ctrl.sv
module flash_unlock_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              gie_i,
  input  logic              dbg_en_i,
  input  logic              flash_busy_i,
  input  logic              xwr_i,
  input  logic [ADDR_W-1:0] xwr_addr_i,
  input  logic [DATA_W-1:0] xwr_data_i,
  output logic [DATA_W-1:0] cmd_rdata_o,
  output logic              pwe_o,
  output logic              erase_page_req_o,
  output logic              erase_mass_req_o,
  output logic [PAGE_W-1:0] erase_page_o,
  output logic              flash_wr_o,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic [DATA_W-1:0] flash_data_o,
  output logic              ram_wr_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_data_o
);
  fu_erase_ctrl #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) i_erase (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr_i),
    .sel       (reg_sel_i),
    .wdata     (reg_wdata_i),
    .busy      (flash_busy_i),
    .dbg_en    (dbg_en_i),
    .cmd_rdata (cmd_rdata_o),
    .page_req  (erase_page_req_o),
    .mass_req  (erase_mass_req_o),
    .page_out  (erase_page_o)
  );

  fu_write_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_route (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr_i),
    .sel        (reg_sel_i),
    .wdata      (reg_wdata_i),
    .gie        (gie_i),
    .busy       (flash_busy_i),
    .xwr        (xwr_i),
    .xaddr      (xwr_addr_i),
    .xdata      (xwr_data_i),
    .pwe        (pwe_o),
    .flash_wr   (flash_wr_o),
    .flash_addr (flash_addr_o),
    .flash_data (flash_data_o),
    .ram_wr     (ram_wr_o),
    .ram_addr   (ram_addr_o),
    .ram_data   (ram_data_o)
  );
endmodule

// File: rtl/fu_checker.sv
module fu_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_i,
  input logic [1:0]        reg_sel_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              gie_i,
  input logic              dbg_en_i,
  input logic              flash_busy_i,
  input logic              xwr_i,
  input logic              pwe_o,
  input logic              erase_page_req_o,
  input logic              erase_mass_req_o,
  input logic              flash_wr_o,
  input logic              ram_wr_o
);
  a_r2_page_req_from_cmd: assert property (@(posedge clk) disable iff (rst)
    erase_page_req_o |-> $past(reg_wr_i && reg_sel_i == 2'd0 &&
                               reg_wdata_i == 8'h55 && !flash_busy_i));

  a_r3_mass_req_needs_dbg: assert property (@(posedge clk) disable iff (rst)
    erase_mass_req_o |-> $past(reg_wr_i && reg_sel_i == 2'd0 &&
                               reg_wdata_i == 8'hAA && dbg_en_i && !flash_busy_i));

  a_r7_no_back_to_back_page: assert property (@(posedge clk) disable iff (rst)
    (erase_page_req_o && !(reg_wr_i && reg_sel_i == 2'd1)) |=> !erase_page_req_o);

  a_r8_single_target: assert property (@(posedge clk) disable iff (rst)
    !(flash_wr_o && ram_wr_o));

  a_r9_pwe_cleared_after_byte: assert property (@(posedge clk) disable iff (rst)
    flash_wr_o |-> !pwe_o);

  a_r10_pwe_rise_needs_gie_off: assert property (@(posedge clk) disable iff (rst)
    $rose(pwe_o) |-> $past(!gie_i));

  a_r11_flash_wr_not_busy: assert property (@(posedge clk) disable iff (rst)
    flash_wr_o |-> $past(xwr_i && !flash_busy_i));
endmodule

bind flash_unlock_ctrl fu_checker #(.DATA_W(DATA_W)) i_fu_checker (
  .clk              (clk),
  .rst              (rst),
  .reg_wr_i         (reg_wr_i),
  .reg_sel_i        (reg_sel_i),
  .reg_wdata_i      (reg_wdata_i),
  .gie_i            (gie_i),
  .dbg_en_i         (dbg_en_i),
  .flash_busy_i     (flash_busy_i),
  .xwr_i            (xwr_i),
  .pwe_o            (pwe_o),
  .erase_page_req_o (erase_page_req_o),
  .erase_mass_req_o (erase_mass_req_o),
  .flash_wr_o       (flash_wr_o),
  .ram_wr_o         (ram_wr_o)
);

// File: tb/test_flash_unlock_ctrl.sv
`timescale 1ns/1ps
module test_flash_unlock_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_sel_i = 2'd0;
  logic [7:0]  reg_wdata_i = 8'h00;
  logic        gie_i = 1'b0;
  logic        dbg_en_i = 1'b0;
  logic        flash_busy_i = 1'b0;
  logic        xwr_i = 1'b0;
  logic [15:0] xwr_addr_i = 16'h0;
  logic [7:0]  xwr_data_i = 8'h0;
  logic [7:0]  cmd_rdata_o;
  logic        pwe_o, erase_page_req_o, erase_mass_req_o;
  logic [6:0]  erase_page_o;
  logic        flash_wr_o, ram_wr_o;
  logic [15:0] flash_addr_o, ram_addr_o;
  logic [7:0]  flash_data_o, ram_data_o;

  int n_chk = 0;
  int n_err = 0;
  logic       c_pr, c_mr, c_fw, c_rw;
  logic [6:0] c_pg;
  logic [15:0] c_fa, c_ra;
  logic [7:0]  c_fd, c_rd;

  always #2 clk = ~clk;

  flash_unlock_ctrl i_flash_unlock_ctrl (
    .clk(clk), .rst(rst), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .gie_i(gie_i), .dbg_en_i(dbg_en_i),
    .flash_busy_i(flash_busy_i), .xwr_i(xwr_i), .xwr_addr_i(xwr_addr_i),
    .xwr_data_i(xwr_data_i), .cmd_rdata_o(cmd_rdata_o), .pwe_o(pwe_o),
    .erase_page_req_o(erase_page_req_o), .erase_mass_req_o(erase_mass_req_o),
    .erase_page_o(erase_page_o), .flash_wr_o(flash_wr_o),
    .flash_addr_o(flash_addr_o), .flash_data_o(flash_data_o),
    .ram_wr_o(ram_wr_o), .ram_addr_o(ram_addr_o), .ram_data_o(ram_data_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_sel_i = s; reg_wdata_i = d;
    @(posedge clk); #1;
    c_pr = erase_page_req_o; c_mr = erase_mass_req_o; c_pg = erase_page_o;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic x_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    xwr_i = 1'b1; xwr_addr_i = a; xwr_data_i = d;
    @(posedge clk); #1;
    c_fw = flash_wr_o; c_fa = flash_addr_o; c_fd = flash_data_o;
    c_rw = ram_wr_o; c_ra = ram_addr_o; c_rd = ram_data_o;
    @(negedge clk);
    xwr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 page req", erase_page_req_o, 0);
    chk("R1 mass req", erase_mass_req_o, 0);
    chk("R1 page", erase_page_o, 0);
    chk("R1 pwe", pwe_o, 0);
    chk("R1 cmd read", cmd_rdata_o, 0);
    chk("R1 flash wr", flash_wr_o, 0);
    chk("R1 ram wr", ram_wr_o, 0);
  endtask

  task automatic t_page_erase();
    wr_reg(2'd1, 8'h7F);
    wr_reg(2'd0, 8'h55);
    chk("R2 page req", c_pr, 1);
    chk("R2 page 127", c_pg, 7'h7F);
    chk("R2 no mass", c_mr, 0);
    chk("R12 cmd read", cmd_rdata_o, 8'h55);
    @(posedge clk); #1;
    chk("R2 pulse one cycle", erase_page_req_o, 0);
    wr_reg(2'd0, 8'h55);
    chk("R5 R7 not rearmed", c_pr, 0);
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd0, 8'h55);
    chk("R2 rearmed page 0 req", c_pr, 1);
    chk("R2 page 0", c_pg, 7'h00);
  endtask

  task automatic t_mass_erase();
    dbg_en_i = 1'b0;
    wr_reg(2'd2, 8'h01);
    wr_reg(2'd0, 8'hAA);
    chk("R6 dbg off dropped", c_mr, 0);
    dbg_en_i = 1'b1;
    wr_reg(2'd0, 8'hAA);
    chk("R3 R6 enable kept mass req", c_mr, 1);
    chk("R3 no page req", c_pr, 0);
    @(posedge clk); #1;
    chk("R3 pulse one cycle", erase_mass_req_o, 0);
    wr_reg(2'd0, 8'hAA);
    chk("R7 enable cleared", c_mr, 0);
    wr_reg(2'd2, 8'h01);
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd0, 8'hAA);
    chk("R6 enable written 0", c_mr, 0);
  endtask

  task automatic t_cross_clear();
    dbg_en_i = 1'b1;
    wr_reg(2'd1, 8'h05);
    wr_reg(2'd2, 8'h01);
    wr_reg(2'd0, 8'hAA);
    chk("R3 mass req", c_mr, 1);
    wr_reg(2'd0, 8'h55);
    chk("R7 page flag cleared by mass", c_pr, 0);
  endtask

  task automatic t_other_values();
    dbg_en_i = 1'b1;
    wr_reg(2'd1, 8'h03);
    wr_reg(2'd2, 8'h01);
    wr_reg(2'd0, 8'h00);
    chk("R4 0x00 no page", c_pr, 0);
    chk("R4 0x00 no mass", c_mr, 0);
    wr_reg(2'd0, 8'h54);
    chk("R4 0x54 no page", c_pr, 0);
    wr_reg(2'd0, 8'hFF);
    chk("R4 0xFF no mass", c_mr, 0);
    chk("R12 cmd read 0xFF", cmd_rdata_o, 8'hFF);
    wr_reg(2'd0, 8'h55);
    chk("R4 page arm kept", c_pr, 1);
    chk("R4 page 3", c_pg, 7'h03);
  endtask

  task automatic t_pwe_route();
    gie_i = 1'b0;
    wr_reg(2'd3, 8'h01);
    chk("R8 pwe set", pwe_o, 1);
    x_wr(16'h1234, 8'hA5);
    chk("R8 flash wr", c_fw, 1);
    chk("R8 flash addr", c_fa, 16'h1234);
    chk("R8 flash data", c_fd, 8'hA5);
    chk("R8 no ram wr", c_rw, 0);
    chk("R9 pwe self clear", pwe_o, 0);
    x_wr(16'h0042, 8'h3C);
    chk("R8 ram wr", c_rw, 1);
    chk("R8 ram addr", c_ra, 16'h0042);
    chk("R8 ram data", c_rd, 8'h3C);
    chk("R8 no flash wr", c_fw, 0);
  endtask

  task automatic t_gie();
    gie_i = 1'b1;
    wr_reg(2'd3, 8'h01);
    chk("R10 set ignored", pwe_o, 0);
    gie_i = 1'b0;
    wr_reg(2'd3, 8'h01);
    gie_i = 1'b1;
    wr_reg(2'd3, 8'h00);
    chk("R10 clear ignored", pwe_o, 1);
    x_wr(16'hBEEF, 8'h11);
    chk("R9 flash wr with gie", c_fw, 1);
    chk("R9 pwe cleared", pwe_o, 0);
    gie_i = 1'b0;
  endtask

  task automatic t_busy();
    wr_reg(2'd0, 8'h12);
    chk("R12 cmd read 0x12", cmd_rdata_o, 8'h12);
    wr_reg(2'd3, 8'h01);
    @(negedge clk);
    flash_busy_i = 1'b1;
    #1;
    chk("R11 cmd read zero", cmd_rdata_o, 8'h00);
    wr_reg(2'd1, 8'h09);
    wr_reg(2'd0, 8'h55);
    chk("R11 page cmd ignored", c_pr, 0);
    x_wr(16'h0100, 8'h77);
    chk("R11 no flash wr", c_fw, 0);
    chk("R11 no ram wr", c_rw, 0);
    chk("R11 pwe kept", pwe_o, 1);
    @(negedge clk);
    flash_busy_i = 1'b0;
    #1;
    chk("R12 cmd kept over busy", cmd_rdata_o, 8'h12);
    wr_reg(2'd0, 8'h55);
    chk("R11 page write in busy armed", c_pr, 1);
    chk("R11 page 9", c_pg, 7'h09);
    x_wr(16'h0101, 8'h66);
    chk("R8 flash wr after busy", c_fw, 1);
  endtask

  initial begin
    #(4 * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_page_erase();
    t_mass_erase();
    t_cross_clear();
    t_other_values();
    t_pwe_route();
    t_gie();
    t_busy();
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule